// File: doc/BRIEF.md
# Selective Harmonic Elimination Gate Generator

This block drives the two switches of one inverter leg from a table of switching angles that were solved offline. A 16-bit phase accumulator advances by a programmable increment on every clock, and a full turn of the accumulator is one fundamental period. The phase is folded into the first quarter-wave and compared with the N stored angles of the selected set. Each angle that the folded phase has reached flips the output level once. The second quarter mirrors the first, and the second half-cycle is the first half-cycle inverted. Both symmetries come from the fold itself, so only one quarter of the waveform is stored.

The amplitude index picks one of 16 angle sets. An index change takes effect only at the next period boundary, so a period never mixes two sets. The output level drives the top gate and the inverted level drives the bottom gate. A dead-time counter holds both gates off after every change of level and then turns on the gate that matches the new level. A strobe marks the start of each period.

Top module: `she_gate_gen`

## Requirements
- R1: The phase register is 0 after reset and on every clock becomes (phase + phase_inc_i) mod 2^16. period_start_o is high for exactly the one cycle after an update that wrapped past 2^16, and is low otherwise.
- R2: Angle k (k = 0..N-1) of set s is (k+1)*S + s*(S/64), where S = 2^14/(N+1) and angles are in phase units. With the defaults this is (k+1)*4096 + 64*s.
- R3: In every set the angles are strictly increasing and all are below 2^14 (a quarter period).
- R4: In the first quarter (phase bits [15:14] = 00), the level is INIT_LVL XOR the parity of the count of angles a with phase[13:0] >= a.
- R5: In the second quarter (bits [15:14] = 01), the level is computed as in R4 with folded phase 2^14 - phase[13:0]. The transitions therefore fall at the mirror points of those in the first quarter.
- R6: In the second half (phase bit 15 = 1), the level is the first-half level of the same folded phase, inverted.
- R7: amp_idx_i is sampled only on the clock that produces period_start_o. The set in use is 0 after reset.
- R8: gate_top_o and gate_bot_o are never high together.
- R9: A level change appears at the gates two clocks after the phase update that caused it. At that point both gates go low. After DEAD_CYC further clocks of the new level held steady, the matching gate goes high (top for level 1, bottom for level 0). A level change during the wait restarts the wait.
- R10: Outside a dead-time wait, exactly one gate is high.
- R11: During reset, gate_top_o = INIT_LVL, gate_bot_o = !INIT_LVL and period_start_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_inc_i | input | PHASE_W | Phase advance per clock |
| amp_idx_i | input | $clog2(N_SETS) | Requested angle set |
| gate_top_o | output | 1 | Top switch gate |
| gate_bot_o | output | 1 | Bottom switch gate |
| period_start_o | output | 1 | One-cycle strobe at each period start |

## Verification
The bench keeps the default accumulator width, three angles and sixteen sets, and shortens the dead time to two cycles. With this short dead time, the fastest increment yields pulses shorter than the wait, so restarted waits are exercised. The bench drives all sixteen sets at three increments: 37, 101 and 4093. At 37 and 101 every quarter, mirror point and sign flip of every set is stepped through with fine resolution. At 4093 the output gets pulses near the dead-time limit. The amplitude index is also changed in the middle of a period to show that the set switches only at the period boundary.

// File: rtl/she_pkg.sv
package she_pkg;
  // angle k of set s, in phase units of a 2^ang_w quarter period
  function automatic int unsigned she_angle(int unsigned s, int unsigned k,
                                            int unsigned n_ang, int unsigned ang_w);
    int unsigned step;
    step = (32'd1 << ang_w) / (n_ang + 1);
    return (k + 1) * step + s * (step / 64);
  endfunction
endpackage

// File: rtl/she_angle_rom.sv
module she_angle_rom #(
  parameter int unsigned N_ANG  = 3,
  parameter int unsigned N_SETS = 16,
  parameter int unsigned ANG_W  = 14,
  localparam int unsigned IDX_W = $clog2(N_SETS)
) (
  input  logic [IDX_W-1:0]            sel_i,
  output logic [N_ANG-1:0][ANG_W-1:0] ang_o
);
  import she_pkg::*;

  logic [N_SETS-1:0][N_ANG-1:0][ANG_W-1:0] table_c;

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    for (genvar k = 0; k < N_ANG; k++) begin : g_ang
      localparam int unsigned A = she_angle(s, k, N_ANG, ANG_W);
      assign table_c[s][k] = ANG_W'(A);
    end
  end

  assign ang_o = table_c[sel_i];
endmodule

// File: rtl/she_phase.sv
module she_phase #(
  parameter int unsigned PHASE_W = 16,
  parameter int unsigned IDX_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] inc_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [PHASE_W-1:0] acc_o,
  output logic [IDX_W-1:0]   sel_o,
  output logic               wrap_o
);
  logic [PHASE_W:0] sum;
  assign sum = {1'b0, acc_o} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      sel_o  <= '0;
      wrap_o <= 1'b0;
    end else begin
      acc_o  <= sum[PHASE_W-1:0];
      wrap_o <= sum[PHASE_W];
      if (sum[PHASE_W]) sel_o <= idx_i;
    end
  end

  AST_WRAP_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o == (acc_o < $past(acc_o))) else $error("wrap strobe mismatch"); // R1
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |-> $stable(sel_o)) else $error("set changed mid-period"); // R7
endmodule

// File: rtl/she_level.sv
module she_level #(
  parameter int unsigned PHASE_W  = 16,
  parameter int unsigned N_ANG    = 3,
  parameter bit          INIT_LVL = 1'b1,
  localparam int unsigned ANG_W   = PHASE_W - 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [PHASE_W-1:0]          acc_i,
  input  logic [N_ANG-1:0][ANG_W-1:0] ang_i,
  output logic                        lvl_o
);
  logic [1:0]     quad;
  logic [ANG_W:0] fold;
  logic [N_ANG-1:0] past_ang;
  logic           lvl_d;

  assign quad = acc_i[PHASE_W-1 -: 2];
  // second quarter mirrors the first around the quarter point
  assign fold = quad[0] ? ((ANG_W+1)'(1) << ANG_W) - {1'b0, acc_i[ANG_W-1:0]}
                        : {1'b0, acc_i[ANG_W-1:0]};

  for (genvar k = 0; k < N_ANG; k++) begin : g_cmp
    assign past_ang[k] = fold >= {1'b0, ang_i[k]};
  end

  assign lvl_d = INIT_LVL ^ (^past_ang) ^ quad[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_o <= INIT_LVL;
    else         lvl_o <= lvl_d;
  end

  AST_ZERO_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == '0) |=> (lvl_o == INIT_LVL)) else $error("level at phase zero"); // R4
endmodule

// File: rtl/she_deadtime.sv
module she_deadtime #(
  parameter int unsigned DEAD_CYC = 4,
  parameter bit          INIT_LVL = 1'b1,
  localparam int unsigned CNT_W   = $clog2(DEAD_CYC + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic top_o,
  output logic bot_o
);
  if (DEAD_CYC == 0) begin : g_nodead
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        top_o <= INIT_LVL;
        bot_o <= !INIT_LVL;
      end else begin
        top_o <= lvl_i;
        bot_o <= !lvl_i;
      end
    end
  end else begin : g_dead
    logic             drv_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        drv_q <= INIT_LVL;
        cnt_q <= '0;
        top_o <= INIT_LVL;
        bot_o <= !INIT_LVL;
      end else if (lvl_i != drv_q) begin
        drv_q <= lvl_i;
        cnt_q <= CNT_W'(DEAD_CYC);
        top_o <= 1'b0;
        bot_o <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          top_o <= drv_q;
          bot_o <= !drv_q;
        end
      end else begin
        top_o <= drv_q;
        bot_o <= !drv_q;
      end
    end

    AST_ONE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == '0) |-> (top_o ^ bot_o)) else $error("gate undefined"); // R10
    AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(top_o) || $rose(bot_o)) |-> $past(!top_o && !bot_o)) else $error("no gap"); // R9
  end

  AST_GATE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(top_o && bot_o)) else $error("shoot-through"); // R8
endmodule

// File: rtl/she_gate_gen.sv
module she_gate_gen #(
  parameter int unsigned PHASE_W  = 16,
  parameter int unsigned N_ANG    = 3,
  parameter int unsigned N_SETS   = 16,
  parameter int unsigned DEAD_CYC = 4,
  parameter bit          INIT_LVL = 1'b1,
  localparam int unsigned IDX_W   = $clog2(N_SETS),
  localparam int unsigned ANG_W   = PHASE_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] phase_inc_i,
  input  logic [IDX_W-1:0]   amp_idx_i,
  output logic               gate_top_o,
  output logic               gate_bot_o,
  output logic               period_start_o
);
  logic [PHASE_W-1:0]          acc;
  logic [IDX_W-1:0]            sel;
  logic [N_ANG-1:0][ANG_W-1:0] ang;
  logic                        lvl;

  she_phase #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) i_phase (
    .clk_i, .rst_ni, .inc_i(phase_inc_i), .idx_i(amp_idx_i),
    .acc_o(acc), .sel_o(sel), .wrap_o(period_start_o)
  );

  she_angle_rom #(.N_ANG(N_ANG), .N_SETS(N_SETS), .ANG_W(ANG_W)) i_rom (
    .sel_i(sel), .ang_o(ang)
  );

  she_level #(.PHASE_W(PHASE_W), .N_ANG(N_ANG), .INIT_LVL(INIT_LVL)) i_level (
    .clk_i, .rst_ni, .acc_i(acc), .ang_i(ang), .lvl_o(lvl)
  );

  she_deadtime #(.DEAD_CYC(DEAD_CYC), .INIT_LVL(INIT_LVL)) i_dead (
    .clk_i, .rst_ni, .lvl_i(lvl), .top_o(gate_top_o), .bot_o(gate_bot_o)
  );

  for (genvar k = 0; k + 1 < N_ANG; k++) begin : g_ord
    AST_ANGLE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ang[k] < ang[k+1]) else $error("angles not increasing"); // R3
  end
  AST_ANGLE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ang[N_ANG-1] != '0) else $error("last angle out of range"); // R3
endmodule

// File: tb/test_she_gate_gen.sv
module test_she_gate_gen;
  localparam int DEAD = 2;
  localparam bit INIT = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] inc = '0;
  logic [3:0]  amp = '0;
  logic        top, bot, stb;

  int n_chk = 0, n_fail = 0;
  bit running = 0;

  always #4 clk = ~clk;

  she_gate_gen #(.DEAD_CYC(DEAD), .INIT_LVL(INIT)) i_she_gate_gen (
    .clk_i(clk), .rst_ni(rst_n), .phase_inc_i(inc), .amp_idx_i(amp),
    .gate_top_o(top), .gate_bot_o(bot), .period_start_o(stb)
  );

  // R2/R4/R5/R6: expected level straight from the angle formula
  function automatic bit ideal(int unsigned acc, int unsigned s);
    int unsigned q, low, f, c;
    q = acc >> 14; low = acc & 16383;
    f = (q & 1) ? 16384 - low : low;
    c = 0;
    for (int k = 0; k < 3; k++) if (f >= (k + 1) * 4096 + s * 64) c++;
    return INIT ^ c[0] ^ q[1];
  endfunction

  int unsigned m_acc, m_sel, m_cnt, m_q;
  bit m_lvl, m_drv, m_top, m_bot, m_stb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_sel = 0; m_lvl = INIT; m_drv = INIT; m_cnt = 0;
      m_top = INIT; m_bot = !INIT; m_stb = 0; m_q = 0;
    end else begin
      bit nl;
      int unsigned sum;
      nl = ideal(m_acc, m_sel);
      m_q = m_acc >> 14;
      if (m_lvl != m_drv) begin
        m_drv = m_lvl; m_cnt = DEAD; m_top = 0; m_bot = 0;
      end else if (m_cnt != 0) begin
        if (m_cnt == 1) begin m_top = m_drv; m_bot = !m_drv; end
        m_cnt--;
      end else begin
        m_top = m_drv; m_bot = !m_drv;
      end
      m_lvl = nl;
      sum = m_acc + inc;
      m_stb = sum[16];
      if (sum[16]) m_sel = amp;   // R7
      m_acc = sum & 16'hffff;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (running) begin
    string tag;
    check(stb == m_stb, "R1 period strobe", stb, m_stb);
    check(!(top && bot), "R8 exclusive gates", {top, bot}, 0);
    if (m_cnt == 0) check(top ^ bot, "R10 one gate on", {top, bot}, 1);
    if (!m_top && !m_bot) tag = "R9 dead time";
    else if (m_q[1]) tag = "R6 inverted half";
    else if (m_q[0]) tag = "R5 mirrored quarter";
    else tag = "R4 first quarter";
    check({top, bot} == {m_top, m_bot}, tag, {top, bot}, {m_top, m_bot});
  end

  task automatic run(int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    int unsigned incs[3] = '{37, 101, 4093};
    repeat (3) @(negedge clk);
    // R11 reset values
    check(top == INIT, "R11 reset top", top, INIT);
    check(bot == !INIT, "R11 reset bot", bot, !INIT);
    check(stb == 0, "R11 reset strobe", stb, 0);
    rst_n = 1'b1;
    running = 1;
    // R1 hold: zero increment never wraps
    run(20);
    foreach (incs[i]) begin
      inc = 16'(incs[i]);
      // R2 R3: every set over a full period at this increment
      for (int s = 0; s < 16; s++) begin
        amp = 4'(s);
        run(65536 / incs[i] + 4);
      end
    end
    // R7: index changed mid-period takes hold only at the wrap
    inc = 16'd101;
    for (int s = 15; s >= 0; s -= 5) begin
      amp = 4'(s);
      run(300);
      amp = 4'(15 - s);
      run(400);
    end
    running = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule